// File: doc/BRIEF.md
# Rotating register loop controller

This block is the control unit for software-pipelined (modulo-scheduled) loops. It holds a loop counter, an epilogue counter, a rotating register base and a bank of stage predicates, one predicate per pipeline stage. The compiler guards each stage of the loop body with its own predicate. A single counted-loop branch at the bottom of the body then decides whether to go round again. On the same branch it rotates the register names by one and pushes a fresh stage predicate into the pipeline.

Software first loads the two counters with a setup strobe. It then pulses the branch strobe once per trip through the body. During the kernel the counter holds remaining iterations, and each branch shifts a 1 into the first stage predicate. Once that counter is spent, the epilogue counter drains the pipeline by shifting in 0s. When both counters are exhausted the branch falls through. For any logical register index the block also gives the physical index: indices 32 to 127 form the rotating region and are renamed, and lower indices pass through unchanged. All pins are plain control and status pins. The branch has no back-pressure, and every accepted strobe gets exactly one response one cycle later.

Top module: `rot_loop_ctrl`

## Requirements
- R1: After reset the response valid is low, all stage predicates are 0, both counters are 0 and the rotating base is 0, so every logical index maps to itself.
- R2: A setup strobe loads the loop counter and the epilogue counter, returns the rotating base to 0 and clears every stage predicate. It produces no branch response.
- R3: When setup and branch strobes arrive in the same cycle, the setup takes effect and the branch is discarded: no response is produced and no counter is decremented by it.
- R4: A branch with a non-zero loop counter is taken. It decrements the loop counter, shifts every stage predicate up by one position (bit i moves to bit i+1, the top bit is lost), puts 1 into bit 0 and rotates the base.
- R5: A branch with a zero loop counter and an epilogue counter greater than 1 is taken. It decrements the epilogue counter, shifts the predicates the same way with 0 into bit 0 and rotates the base.
- R6: A branch with a zero loop counter and an epilogue counter of 0 or 1 is not taken. It leaves the epilogue counter at 0 and changes neither the predicates nor the base.
- R7: Each rotation decrements the base modulo 96, from 0 to 95. A register written under logical index r before a rotation is found under logical index r+1 after it.
- R8: For logical index L from 32 to 127, the physical index is 32 + ((L - 32 + base) mod 96). For L below 32, the physical index equals L. The mapping is combinational.
- R9: Each accepted branch gives one cycle of response valid on the cycle after the strobe, with the taken flag set as in R4 to R6. The predicates and base shown in that cycle already hold the post-branch values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_en | input | 1 | Load counters, clear base and predicates |
| setup_lc | input | 16 | Loop counter value loaded by setup |
| setup_ec | input | 16 | Epilogue counter value loaded by setup |
| br_en | input | 1 | Execute the counted-loop branch this cycle |
| resp_valid | output | 1 | Branch response valid (one cycle) |
| resp_taken | output | 1 | Branch taken, qualified by resp_valid |
| stage_pred | output | 48 | Rotating stage predicates, bit 0 is the first stage |
| log_idx | input | 7 | Logical register index to rename |
| phys_idx | output | 7 | Physical register index for log_idx |

## Verification
Setup and branch can both be requested in the same cycle. The bench provokes this by raising both strobes on one edge after the base has been moved away from 0 and the predicates have been filled. It then checks that no response appears, that the predicates read as all zero, and that renaming has returned to identity. It also checks that the following branches count down from the newly loaded values rather than from values decremented once more.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [1:0] {
    BR_LOOP  = 2'd0,
    BR_DRAIN = 2'd1,
    BR_EXIT  = 2'd2
  } br_kind_e;

  typedef struct packed {
    logic rotate;
    logic fresh;
    logic taken;
  } br_act_t;
endpackage

// File: rtl/rlc_count_unit.sv
module rlc_count_unit
  import rlc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_lc,
  input  logic [CNT_W-1:0] load_ec,
  input  logic             fire,
  output br_act_t          act
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lc_q, ec_q;
  br_kind_e         kind;

  always_comb begin
    if (lc_q != '0)      kind = BR_LOOP;
    else if (ec_q > ONE) kind = BR_DRAIN;
    else                 kind = BR_EXIT;
  end

  always_comb begin
    unique case (kind)
      BR_LOOP:  act = '{rotate: 1'b1, fresh: 1'b1, taken: 1'b1};
      BR_DRAIN: act = '{rotate: 1'b1, fresh: 1'b0, taken: 1'b1};
      default:  act = '{rotate: 1'b0, fresh: 1'b0, taken: 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc_q <= '0;
      ec_q <= '0;
    end else if (load) begin
      lc_q <= load_lc;
      ec_q <= load_ec;
    end else if (fire) begin
      unique case (kind)
        BR_LOOP:  lc_q <= lc_q - ONE;
        BR_DRAIN: ec_q <= ec_q - ONE;
        default:  ec_q <= '0;
      endcase
    end
  end

  // R2: setup loads both counters
  a_r2_load_counters: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lc_q == $past(load_lc)) && (ec_q == $past(load_ec)));

  // R4: kernel branch consumes one loop count, epilogue untouched
  a_r4_loop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && kind == BR_LOOP) |=> (lc_q == $past(lc_q) - ONE) && $stable(ec_q));

  // R5: drain branch consumes one epilogue count
  a_r5_drain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && kind == BR_DRAIN) |=> (ec_q == $past(ec_q) - ONE) && (lc_q == '0));

  // R6: exit leaves both counters empty
  a_r6_exit_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && kind == BR_EXIT) |=> (ec_q == '0) && (lc_q == '0));
endmodule

// File: rtl/rlc_rot_base.sv
module rlc_rot_base #(
  parameter int ROT_SIZE = 96,
  parameter int BASE_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [BASE_W-1:0] base
);
  localparam logic [BASE_W-1:0] LAST = BASE_W'(ROT_SIZE - 1);
  localparam logic [BASE_W-1:0] ONE  = BASE_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       base <= '0;
    else if (clr)     base <= '0;
    else if (step)    base <= (base == '0) ? LAST : base - ONE;
  end

  // R7: base always stays inside the rotating region
  a_r7_base_range: assert property (@(posedge clk) disable iff (!rst_n)
    base <= LAST);

  // R7: one rotation moves the base down by one, wrapping at zero
  a_r7_base_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && base == '0) |=> base == LAST);
endmodule

// File: rtl/rlc_pred_shift.sv
module rlc_pred_shift #(
  parameter int PRED_N = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              fresh,
  output logic [PRED_N-1:0] pred
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pred <= '0;
    else if (clr)   pred <= '0;
    else if (step)  pred <= {pred[PRED_N-2:0], fresh};
  end

  // R2: setup clears the stage predicates
  a_r2_pred_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pred == '0);

  // R4: fresh predicate lands in the first stage, older stages move up
  a_r4_pred_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (pred[0] == $past(fresh)) && (pred[1] == $past(pred[0])));
endmodule

// File: rtl/rlc_renamer.sv
module rlc_renamer #(
  parameter int ROT_FIRST = 32,
  parameter int ROT_SIZE  = 96,
  parameter int GR_W      = 7,
  parameter int BASE_W    = 7
) (
  input  logic [GR_W-1:0]   log_idx,
  input  logic [BASE_W-1:0] base,
  output logic [GR_W-1:0]   phys_idx
);
  localparam int SUM_W = GR_W + 1;
  localparam logic [SUM_W-1:0] FIRST_S = SUM_W'(ROT_FIRST);
  localparam logic [SUM_W-1:0] SIZE_S  = SUM_W'(ROT_SIZE);
  localparam logic [GR_W-1:0]  FIRST_G = GR_W'(ROT_FIRST);

  logic [SUM_W-1:0] rel, sum, wrapped;
  logic             in_rot;

  always_comb begin
    in_rot  = (log_idx >= FIRST_G);
    rel     = SUM_W'(log_idx) - FIRST_S;
    sum     = rel + SUM_W'(base);
    wrapped = (sum >= SIZE_S) ? sum - SIZE_S : sum;
    phys_idx = in_rot ? GR_W'(wrapped + FIRST_S) : log_idx;
  end

  // R8: rotating indices never rename outside the rotating region
  always_comb begin
    if (!$isunknown({log_idx, base})) begin
      a_r8_stay_in_region: assert (!in_rot || phys_idx >= FIRST_G);
    end
  end
endmodule

// File: rtl/rot_loop_ctrl.sv
module rot_loop_ctrl
  import rlc_pkg::*;
#(
  parameter int NUM_GR    = 128,
  parameter int ROT_FIRST = 32,
  parameter int PRED_N    = 48,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_en,
  input  logic [CNT_W-1:0]  setup_lc,
  input  logic [CNT_W-1:0]  setup_ec,
  input  logic              br_en,
  output logic              resp_valid,
  output logic              resp_taken,
  output logic [PRED_N-1:0] stage_pred,
  input  logic [$clog2(NUM_GR)-1:0] log_idx,
  output logic [$clog2(NUM_GR)-1:0] phys_idx
);
  localparam int GR_W     = $clog2(NUM_GR);
  localparam int ROT_SIZE = NUM_GR - ROT_FIRST;
  localparam int BASE_W   = $clog2(ROT_SIZE);

  br_act_t           act;
  logic              fire;
  logic [BASE_W-1:0] base;

  // setup has priority over a branch in the same cycle
  assign fire = br_en & ~setup_en;

  rlc_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(setup_en),
    .load_lc(setup_lc), .load_ec(setup_ec),
    .fire(fire), .act(act)
  );

  rlc_rot_base #(.ROT_SIZE(ROT_SIZE), .BASE_W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .clr(setup_en),
    .step(fire & act.rotate), .base(base)
  );

  rlc_pred_shift #(.PRED_N(PRED_N)) u_pred (
    .clk(clk), .rst_n(rst_n), .clr(setup_en),
    .step(fire & act.rotate), .fresh(act.fresh), .pred(stage_pred)
  );

  rlc_renamer #(.ROT_FIRST(ROT_FIRST), .ROT_SIZE(ROT_SIZE),
                .GR_W(GR_W), .BASE_W(BASE_W)) u_ren (
    .log_idx(log_idx), .base(base), .phys_idx(phys_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_taken <= 1'b0;
    end else begin
      resp_valid <= fire;
      resp_taken <= fire & act.taken;
    end
  end

  // R9: each accepted branch answers on the next cycle
  a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    br_en && !setup_en |=> resp_valid);

  // R3: setup swallows a simultaneous branch
  a_r3_setup_wins: assert property (@(posedge clk) disable iff (!rst_n)
    setup_en |=> !resp_valid);

  // R6: a fall-through leaves base and predicates alone
  a_r6_exit_still: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_taken) |-> (base == $past(base)) && (stage_pred == $past(stage_pred)));
endmodule

// File: tb/sim_rot_loop_ctrl.sv
module sim_rot_loop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_GR = 128;
  localparam int ROT_FIRST = 32;
  localparam int ROT_SIZE = 96;
  localparam int PRED_N = 48;
  localparam int CNT_W = 16;
  localparam int GR_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_en = 1'b0;
  logic [CNT_W-1:0] setup_lc = '0, setup_ec = '0;
  logic br_en = 1'b0;
  logic resp_valid, resp_taken;
  logic [PRED_N-1:0] stage_pred;
  logic [GR_W-1:0] log_idx = '0;
  logic [GR_W-1:0] phys_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_loop_ctrl #(.NUM_GR(NUM_GR), .ROT_FIRST(ROT_FIRST), .PRED_N(PRED_N), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .setup_en(setup_en), .setup_lc(setup_lc),
    .setup_ec(setup_ec), .br_en(br_en), .resp_valid(resp_valid),
    .resp_taken(resp_taken), .stage_pred(stage_pred),
    .log_idx(log_idx), .phys_idx(phys_idx)
  );

  typedef struct {
    logic              taken;
    logic [PRED_N-1:0] pred;
    string             req;
  } exp_t;

  exp_t sb_q[$];
  int n_total = 0, n_fail = 0;
  bit finished = 0;

  // bench reference state
  int m_lc = 0, m_ec = 0, m_base = 0;
  logic [PRED_N-1:0] m_pred = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic int exp_phys(input int l);
    if (l < ROT_FIRST) return l;
    return ROT_FIRST + ((l - ROT_FIRST + m_base) % ROT_SIZE);
  endfunction

  // monitor: pops the scoreboard whenever a response shows up
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(resp_taken == e.taken, e.req, "taken", longint'(resp_taken), longint'(e.taken));
        check(stage_pred == e.pred, e.req, "predicates", longint'(stage_pred), longint'(e.pred));
      end
    end
  end

  // driver: one branch strobe, expected response queued first
  task automatic do_branch(input string req);
    exp_t e;
    bit rot, fr;
    rot = 1'b0; fr = 1'b0;
    if (m_lc != 0) begin m_lc--; rot = 1; fr = 1; e.taken = 1; end
    else if (m_ec > 1) begin m_ec--; rot = 1; fr = 0; e.taken = 1; end
    else begin m_ec = 0; e.taken = 0; end
    if (rot) begin
      m_pred = {m_pred[PRED_N-2:0], fr};
      m_base = (m_base + ROT_SIZE - 1) % ROT_SIZE;
    end
    e.pred = m_pred;
    e.req = req;
    sb_q.push_back(e);
    @(negedge clk) br_en = 1'b1;
    @(negedge clk) br_en = 1'b0;
  endtask

  task automatic do_setup(input int lc, input int ec, input bit with_br);
    @(negedge clk);
    setup_en = 1'b1; setup_lc = CNT_W'(lc); setup_ec = CNT_W'(ec); br_en = with_br;
    @(negedge clk);
    setup_en = 1'b0; br_en = 1'b0;
    m_lc = lc; m_ec = ec; m_base = 0; m_pred = '0;
    check(resp_valid == 1'b0, with_br ? "R3" : "R2", "no response after setup",
          longint'(resp_valid), 0);
    check(stage_pred == '0, "R2", "predicates cleared", longint'(stage_pred), 0);
  endtask

  task automatic check_phys(input int l, input string req);
    int ex;
    log_idx = GR_W'(l);
    #1;
    ex = exp_phys(l);
    check(int'(phys_idx) == ex, req, $sformatf("phys of %0d", l), longint'(phys_idx), longint'(ex));
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(resp_valid == 1'b0, "R1", "resp_valid", longint'(resp_valid), 0);
    check(stage_pred == '0, "R1", "predicates", longint'(stage_pred), 0);
    check_phys(40, "R1");
    check_phys(127, "R1");
    // R6: branch with both counters empty after reset
    do_branch("R6");
    check_phys(32, "R6");

    // R4 then R5 then R6: three kernel trips, two drain trips, exit
    do_setup(3, 3, 1'b0);
    for (int i = 0; i < 3; i++) do_branch("R4");
    for (int i = 0; i < 2; i++) do_branch("R5");
    do_branch("R6");
    // R7/R8: base is 91 after five rotations
    check_phys(32, "R7");
    check_phys(127, "R8");
    check_phys(80, "R8");
    check_phys(5, "R8");
    check_phys(31, "R8");
    // R6: extra branch after exit changes nothing
    do_branch("R6");
    check_phys(32, "R6");

    // R3: setup and branch together, setup wins
    do_setup(2, 1, 1'b1);
    check_phys(32, "R3");
    do_branch("R4");
    check_phys(32, "R7");  // base wrapped 0 -> 95
    // R7: a value under logical 60 is found under 61 after one rotation
    log_idx = GR_W'(60); #1; p = int'(phys_idx);
    do_branch("R4");
    log_idx = GR_W'(61); #1;
    check(int'(phys_idx) == p, "R7", "renaming follows rotation", longint'(phys_idx), longint'(p));
    do_branch("R6");  // epilogue count of 1 exits at once

    // R9/R4/R5: long loop, predicate bits fall off the top, base wraps again
    do_setup(100, 2, 1'b0);
    for (int i = 0; i < 100; i++) do_branch("R4");
    do_branch("R5");
    do_branch("R6");
    check_phys(32, "R7");
    check_phys(100, "R8");

    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R9", "all responses arrived", longint'(sb_q.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule